// File: doc/BRIEF.md
# ISA I/O Decoder for a Four-Channel UART Bank

This block sits between an 8-bit ISA-style I/O bus and a bank of four 16550-compatible UART channels plus the bidirectional data transceiver that isolates their data lines from the host. It compares the upper address bits with a 4-bit base value set by jumpers. On a match, with a read or write strobe active and no DMA cycle in progress, it selects one channel and opens the data transceiver.

Address bits 5..3 pick the channel. Each channel owns eight consecutive register bytes, and the three lowest address bits pass on to the UARTs as the register select. The interrupt requests of the four channels are merged and steered to one of eight host IRQ lines, chosen by a 3-bit jumper code.

All outputs are registered on `clk` and follow the bus inputs with one clock of latency. The bus reset, sampled on the same clock, drives all selects, the transceiver enable and all IRQ lines inactive.

Top module: `isa_uart_decode`

## Requirements
- R1: One clock after an access cycle (`bus_aen` low, `bus_addr[9:6]` equal to `base_jmp`, `bus_ior_n` or `bus_iow_n` low, `bus_addr[5:3]` = k with k in 0..3), `chan_cs_n[k]` is low and the other three chip selects are high.
- R2: When `bus_addr[9:6]` differs from `base_jmp`, every chip select stays high and `buf_en_n` stays high.
- R3: Channel codes 4 to 7 on `bus_addr[5:3]` assert no chip select, even when the base matches and a strobe is active.
- R4: With both `bus_ior_n` and `bus_iow_n` high, no chip select asserts and `buf_en_n` stays high.
- R5: While `bus_aen` is high, no chip select asserts and `buf_en_n` stays high, whatever the address and strobes.
- R6: `buf_en_n` is low one clock after any cycle with `bus_aen` low, a base match and an active strobe, whatever the channel code.
- R7: `buf_dir` is 1 (transceiver drives toward the host) one clock after `bus_ior_n` is low, and 0 otherwise.
- R8: `reg_sel` equals `bus_addr[2:0]` of the previous clock.
- R9: `irq_out[irq_sel]` is the OR of `chan_int[3:0]` from the previous clock, and every other `irq_out` bit is 0. Bit k of `irq_out` is meant for host line 3, 4, 5, 7, 9, 10, 11 or 15, in that order for k = 0 to 7.
- R10: One clock after `bus_rst` is high, all chip selects and `buf_en_n` are high and `irq_out` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decode clock |
| bus_rst | input | 1 | Bus reset, active high, sampled synchronously |
| bus_addr | input | 10 | I/O address lines 9..0 |
| bus_ior_n | input | 1 | I/O read strobe, active low |
| bus_iow_n | input | 1 | I/O write strobe, active low |
| bus_aen | input | 1 | DMA address enable; high marks a non-I/O cycle |
| base_jmp | input | 4 | Jumper value compared with address bits 9..6 |
| irq_sel | input | 3 | Jumper code choosing the active IRQ output |
| chan_int | input | 4 | Interrupt request of each UART channel, active high |
| chan_cs_n | output | 4 | Chip select per channel, active low |
| buf_en_n | output | 1 | Data transceiver enable, active low |
| buf_dir | output | 1 | Transceiver direction, 1 = toward host |
| reg_sel | output | 3 | Register select for the addressed channel |
| irq_out | output | 8 | Host IRQ lines, active high |

## Verification
Directed cycles read and write each of the four channels, so that a swap between channels or a dropped strobe shows up. They then present near-miss addresses: a base that differs in a single bit, channel codes 4 to 7, and cycles with no strobe or with `bus_aen` high. These separate a decoder that compares too few bits from one that qualifies its selects correctly. Every IRQ code is tried with no channel interrupt, with one and with several, to show that the interrupts are merged and that only the chosen line moves. A long run of pseudo-random addresses, strobes, jumpers and reset pulses, checked on every clock against a behavioural model, reaches the remaining combinations.

// File: rtl/isa_uart_pkg.sv
package isa_uart_pkg;
    localparam int ADDR_W  = 10;
    localparam int BASE_W  = 4;
    localparam int REG_W   = 3;
    localparam int NUM_CH  = 4;
    localparam int IRQ_N   = 8;
    localparam int CH_W    = ADDR_W - BASE_W - REG_W;
    localparam int SEL_W   = $clog2(IRQ_N);

    typedef struct packed {
        logic [NUM_CH-1:0] cs_n;
        logic              buf_en_n;
        logic              buf_dir;
        logic [REG_W-1:0]  reg_sel;
        logic [IRQ_N-1:0]  irq;
    } dec_out_t;
endpackage

// File: rtl/base_cmp.sv
module base_cmp #(
    parameter int BASE_W = 4
) (
    input  logic [BASE_W-1:0] upper_addr,
    input  logic [BASE_W-1:0] jumper,
    output logic              hit
);
    always_comb begin
        hit = 1'b1;
        for (int b = 0; b < BASE_W; b++) begin
            if (upper_addr[b] != jumper[b]) hit = 1'b0;
        end
    end
endmodule

// File: rtl/chan_sel.sv
module chan_sel #(
    parameter int CH_W   = 3,
    parameter int NUM_CH = 4
) (
    input  logic [CH_W-1:0]   chan_code,
    input  logic              access,
    output logic [NUM_CH-1:0] sel_n
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign sel_n[i] = !(access && (chan_code == CH_W'(i)));
    end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
    parameter int NUM_CH = 4,
    parameter int IRQ_N  = 8,
    parameter int SEL_W  = 3
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [SEL_W-1:0]  code,
    output logic [IRQ_N-1:0]  lines
);
    logic any_req;
    assign any_req = |req;

    for (genvar k = 0; k < IRQ_N; k++) begin : g_line
        assign lines[k] = any_req && (code == SEL_W'(k));
    end
endmodule

// File: rtl/isa_uart_decode.sv
module isa_uart_decode
    import isa_uart_pkg::*;
(
    input  logic              clk,
    input  logic              bus_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ior_n,
    input  logic              bus_iow_n,
    input  logic              bus_aen,
    input  logic [BASE_W-1:0] base_jmp,
    input  logic [SEL_W-1:0]  irq_sel,
    input  logic [NUM_CH-1:0] chan_int,
    output logic [NUM_CH-1:0] chan_cs_n,
    output logic              buf_en_n,
    output logic              buf_dir,
    output logic [REG_W-1:0]  reg_sel,
    output logic [IRQ_N-1:0]  irq_out
);
    localparam int CH_LO   = REG_W;
    localparam int BASE_LO = REG_W + CH_W;

    logic              base_hit;
    logic              strobe;
    logic              access;
    logic [NUM_CH-1:0] sel_n;
    logic [IRQ_N-1:0]  irq_lines;
    dec_out_t          out_d, out_q;

    base_cmp #(.BASE_W(BASE_W)) u_base (
        .upper_addr (bus_addr[BASE_LO +: BASE_W]),
        .jumper     (base_jmp),
        .hit        (base_hit)
    );

    assign strobe = !bus_ior_n || !bus_iow_n;
    assign access = base_hit && strobe && !bus_aen;

    chan_sel #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_chan (
        .chan_code (bus_addr[CH_LO +: CH_W]),
        .access    (access),
        .sel_n     (sel_n)
    );

    irq_route #(.NUM_CH(NUM_CH), .IRQ_N(IRQ_N), .SEL_W(SEL_W)) u_irq (
        .req   (chan_int),
        .code  (irq_sel),
        .lines (irq_lines)
    );

    always_comb begin
        out_d          = out_q;
        out_d.buf_dir  = !bus_ior_n;
        out_d.reg_sel  = bus_addr[REG_W-1:0];
        if (bus_rst) begin
            out_d.cs_n     = '1;
            out_d.buf_en_n = 1'b1;
            out_d.irq      = '0;
        end else begin
            out_d.cs_n     = sel_n;
            out_d.buf_en_n = !access;
            out_d.irq      = irq_lines;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign chan_cs_n = out_q.cs_n;
    assign buf_en_n  = out_q.buf_en_n;
    assign buf_dir   = out_q.buf_dir;
    assign reg_sel   = out_q.reg_sel;
    assign irq_out   = out_q.irq;

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (bus_rst)
        $onehot0(~chan_cs_n));

    // R1
    cs_needs_buf_chk: assert property (@(posedge clk) disable iff (bus_rst)
        (chan_cs_n != '1) |-> !buf_en_n);

    // R5
    aen_blocks_chk: assert property (@(posedge clk) disable iff (bus_rst)
        $past(bus_aen) |-> (chan_cs_n == '1) && buf_en_n);

    // R4
    no_strobe_chk: assert property (@(posedge clk) disable iff (bus_rst)
        ($past(bus_ior_n) && $past(bus_iow_n)) |-> (chan_cs_n == '1) && buf_en_n);

    // R7
    dir_follow_chk: assert property (@(posedge clk) disable iff (bus_rst)
        buf_dir == !$past(bus_ior_n));

    // R8
    reg_pass_chk: assert property (@(posedge clk) disable iff (bus_rst)
        reg_sel == $past(bus_addr[REG_W-1:0]));

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (bus_rst)
        $countones(irq_out) <= 1);

    // R10
    reset_quiet_chk: assert property (@(posedge clk) disable iff (bus_rst)
        $past(bus_rst) |-> (chan_cs_n == '1) && buf_en_n && (irq_out == '0));
endmodule

// File: tb/sim_isa_uart_decode.sv
module sim_isa_uart_decode;
    logic       clk = 1'b0;
    logic       bus_rst;
    logic [9:0] bus_addr;
    logic       bus_ior_n, bus_iow_n, bus_aen;
    logic [3:0] base_jmp;
    logic [2:0] irq_sel;
    logic [3:0] chan_int;
    logic [3:0] chan_cs_n;
    logic       buf_en_n, buf_dir;
    logic [2:0] reg_sel;
    logic [7:0] irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    isa_uart_decode u0 (
        .clk(clk), .bus_rst(bus_rst), .bus_addr(bus_addr),
        .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_aen(bus_aen),
        .base_jmp(base_jmp), .irq_sel(irq_sel), .chan_int(chan_int),
        .chan_cs_n(chan_cs_n), .buf_en_n(buf_en_n), .buf_dir(buf_dir),
        .reg_sel(reg_sel), .irq_out(irq_out)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Applies one bus cycle at a falling edge, then compares outputs one
    // falling edge later against a behavioural model of the requirements.
    task automatic step(string tag, bit rst, int addr, bit ior_n, bit iow_n,
                        bit aen, int base, int isel, int ints);
        int exp_cs, exp_en, exp_dir, exp_reg, exp_irq, ch;
        bit access;
        bus_rst = rst; bus_addr = addr[9:0]; bus_ior_n = ior_n; bus_iow_n = iow_n;
        bus_aen = aen; base_jmp = base[3:0]; irq_sel = isel[2:0]; chan_int = ints[3:0];
        ch      = (addr / 8) % 8;
        access  = !rst && !aen && (((addr / 64) % 16) == base) && (!ior_n || !iow_n);
        exp_cs  = 15;
        if (access && ch < 4) exp_cs = 15 - (1 << ch);
        exp_en  = access ? 0 : 1;
        exp_dir = ior_n ? 0 : 1;
        exp_reg = addr % 8;
        exp_irq = (!rst && (ints % 16) != 0) ? (1 << isel) : 0;
        @(posedge clk);
        @(negedge clk);
        check(tag, "R1 chan_cs_n", int'(chan_cs_n), exp_cs);
        check(tag, "R6 buf_en_n", int'(buf_en_n), exp_en);
        check(tag, "R7 buf_dir", int'(buf_dir), exp_dir);
        check(tag, "R8 reg_sel", int'(reg_sel), exp_reg);
        check(tag, "R9 irq_out", int'(irq_out), exp_irq);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        bus_rst = 1; bus_addr = 0; bus_ior_n = 1; bus_iow_n = 1; bus_aen = 0;
        base_jmp = 0; irq_sel = 0; chan_int = 0;
        @(negedge clk);
        // R10 reset holds everything quiet even with a matching access
        step("R10", 1, 10'h300, 0, 1, 0, 12, 2, 4'hF);
        step("R10", 1, 10'h308, 1, 0, 0, 12, 5, 4'h1);
        base = 12;
        // R1 each channel, read and write
        for (int c = 0; c < 4; c++) begin
            step("R1", 0, base * 64 + c * 8 + c, 0, 1, 0, base, 0, 0);
            step("R1", 0, base * 64 + c * 8 + 7 - c, 1, 0, 0, base, 0, 0);
        end
        // R2 base differs in each single bit
        for (int b = 0; b < 4; b++)
            step("R2", 0, (base ^ (1 << b)) * 64 + 8, 0, 1, 0, base, 0, 0);
        // R3 channel codes 4..7
        for (int c = 4; c < 8; c++)
            step("R3", 0, base * 64 + c * 8 + 1, 1, 0, 0, base, 0, 0);
        // R4 no strobe
        step("R4", 0, base * 64 + 16, 1, 1, 0, base, 0, 0);
        // R5 AEN high
        step("R5", 0, base * 64 + 24, 0, 1, 1, base, 0, 0);
        step("R5", 0, base * 64, 1, 0, 1, base, 0, 0);
        // R7 both strobes low still reads toward host
        step("R7", 0, base * 64 + 8, 0, 0, 0, base, 0, 0);
        // R9 every IRQ code with no, one and several channel interrupts
        for (int s = 0; s < 8; s++) begin
            step("R9", 0, 0, 1, 1, 0, base, s, 0);
            step("R9", 0, 0, 1, 1, 0, base, s, 1 << (s % 4));
            step("R9", 0, 0, 1, 1, 0, base, s, 4'hA);
        end
        // R6 base 0 and base 15 edge values
        step("R6", 0, 10'h018, 0, 1, 0, 0, 0, 0);
        step("R6", 0, 10'h3C0, 1, 0, 0, 15, 0, 0);
        // R10 reset pulse mid-run
        step("R10", 1, 10'h3C0, 0, 1, 0, 15, 7, 4'h8);
        // mixed pseudo-random cycles
        for (int n = 0; n < 600; n++) begin
            int a, bs;
            bs = $urandom_range(15);
            a  = $urandom_range(1023);
            if ($urandom_range(1)) a = bs * 64 + (a % 64);
            step("MIX", ($urandom_range(40) == 0), a, $urandom_range(1), $urandom_range(1),
                 ($urandom_range(5) == 0), bs, $urandom_range(7), $urandom_range(15));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule